// File: doc/BRIEF.md
# Buffered printer output port

This block is a character output device placed between a processor-side register bus (local side) and a host-side register port (remote side). Software on the processor writes characters into a data register and watches a status register for a ready flag. The host drains the queued characters through its own register view. An attention pulse tells the host that work has arrived, and an interrupt request tells the processor that the port can take more output.

A parameter `BUF_AW` selects the storage. When it is zero, one holding register is used and the ready flag drops for each character. When it is non-zero, a queue holding `2**BUF_AW - 1` characters is used and the ready flag drops only when that queue is full. An error bit that the host controls empties the queue and blocks all further output until the host clears it.

Each side accesses the port in single cycles. `*_sel_i` picks the register: 0 is status and 1 is data. Read data is combinational in the cycle of the access. A remote data read with `rem_rd_i` high removes the entry it returns at the next clock edge.

Top module: `prt_port`

## Requirements
- R1: The local status view has error at bit 15, done at bit 7 and interrupt enable at bit 6, with all other bits zero. Interrupt enable is written only by local status writes. Error is written only by remote status writes. Done ignores writes from both sides. A local read of the data register returns zero.
- R2: `bus_reset_i` sets done, clears interrupt enable and empties the storage. Error and the rate-limit field keep their values.
- R3: Only bits 6:0 of a local data write are stored. For example, 0x0F8 is read back as 0x78.
- R4: A remote data read returns a valid flag at bit 15, the entry count at bits 14:8 (the count includes the entry being read) and the character at bits 6:0. In buffered mode, a read of an empty queue raises `rem_err_o`, returns zero and changes no state.
- R5: In buffered mode the queue holds `2**BUF_AW-1` characters. Done is 0 only while the queue is full. A write into a full queue is dropped.
- R6: In buffered mode, `attn_o` pulses for one cycle after a local write that lands in an empty queue. No other write pulses it.
- R7: A remote write that sets error flushes the queue. While error is 1, local data writes are discarded and `attn_o` stays low.
- R8: In unbuffered mode:
  - A local write clears done and pulses `attn_o`.
  - A remote data read sets done again.
  - Setting error while a character is pending sets done, marks the character invalid and pulses `attn_o`.
  - A remote read with nothing pending returns valid 0 and raises no error.
- R9: The remote status view shows error at bit 15, a 3-bit rate limit at bits 14:12, the type (equal to `BUF_AW`) at bits 10:8, done at bit 7 and interrupt enable at bit 6. The rate limit is written only by the remote side and always reads as zero locally.
- R10: `irq_o` rises one cycle after (done AND interrupt enable) becomes true. It stays high until `irq_ack_i` is seen or either bit drops. It does not rise again while the condition stays true.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_reset_i | input | 1 | Synchronous bus reset pulse |
| loc_wr_i | input | 1 | Local write strobe |
| loc_sel_i | input | 1 | Local register select, 0 status and 1 data |
| loc_wdata_i | input | 16 | Local write data |
| loc_rdata_o | output | 16 | Local read data |
| rem_wr_i | input | 1 | Remote write strobe |
| rem_rd_i | input | 1 | Remote read strobe |
| rem_sel_i | input | 1 | Remote register select, 0 status and 1 data |
| rem_wdata_i | input | 16 | Remote write data |
| rem_rdata_o | output | 16 | Remote read data |
| rem_err_o | output | 1 | Remote data read hit an empty queue |
| attn_o | output | 1 | Attention pulse toward the host |
| irq_ack_i | input | 1 | Interrupt acknowledge |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check four properties on every cycle:
- After a bus reset, done is set, interrupt enable is clear and error has not moved.
- While error is set, attention stays quiet.
- A full queue stays full under a write with no drain.
- The interrupt request and the empty-read error only appear when done is 1.

Only the bench scenarios can show the following:
- The order of characters through the queue and the size count on each read.
- Which writes cause attention.
- The per-side write permissions and field positions.
- The invalid-character behaviour of the unbuffered variant.

// File: rtl/prt_pkg.sv
package prt_pkg;
  localparam int CHAR_W   = 7;
  localparam int SIZE_W   = 7;
  localparam int RLIM_W   = 3;
  localparam int ST_ERR   = 15;
  localparam int ST_DONE  = 7;
  localparam int ST_IE    = 6;
  localparam int RLIM_LSB = 12;
  localparam int TYPE_LSB = 8;
  localparam int BUF_VAL  = 15;
  localparam int SIZE_LSB = 8;

  typedef struct packed {
    logic              val;
    logic [SIZE_W-1:0] size;
    logic              pad;
    logic [CHAR_W-1:0] data;
  } rbuf_t;
endpackage

// File: rtl/prt_csr.sv
module prt_csr
  import prt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_reset_i,
  input  logic              loc_st_wr_i,
  input  logic              rem_st_wr_i,
  input  logic [15:0]       loc_wdata_i,
  input  logic [15:0]       rem_wdata_i,
  input  logic              done_i,
  input  logic              irq_ack_i,
  output logic              err_o,
  output logic              err_rise_o,
  output logic              ie_o,
  output logic [RLIM_W-1:0] rlim_o,
  output logic              irq_o
);
  logic err_q, ie_q, cond_q, pend_q;
  logic [RLIM_W-1:0] rlim_q;
  logic cond;

  assign cond       = done_i & ie_q;
  assign err_rise_o = rem_st_wr_i & rem_wdata_i[ST_ERR] & ~err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q  <= 1'b0;
      rlim_q <= '0;
      ie_q   <= 1'b0;
      cond_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (rem_st_wr_i) begin
        err_q  <= rem_wdata_i[ST_ERR];
        rlim_q <= rem_wdata_i[RLIM_LSB +: RLIM_W];
      end
      if (bus_reset_i)      ie_q <= 1'b0;
      else if (loc_st_wr_i) ie_q <= loc_wdata_i[ST_IE];
      cond_q <= cond;
      // edge-triggered request, held until ack or condition loss
      pend_q <= cond & ((~cond_q) | (pend_q & ~irq_ack_i));
    end
  end

  assign err_o  = err_q;
  assign ie_o   = ie_q;
  assign rlim_o = rlim_q;
  assign irq_o  = pend_q & cond;
endmodule

// File: rtl/prt_fifo.sv
module prt_fifo
  import prt_pkg::*;
#(
  parameter int AW = 2,
  parameter int DW = CHAR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              err_rise_i,
  input  logic              push_i,
  input  logic [DW-1:0]     push_data_i,
  input  logic              pop_i,
  output logic              done_o,
  output logic              val_o,
  output logic [SIZE_W-1:0] size_o,
  output logic [DW-1:0]     data_o,
  output logic              empty_o,
  output logic              attn_o
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] CAP = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q, cnt_q;
  logic full, empty, push_ok, pop_ok, clr, attn_q;

  assign clr     = flush_i | err_rise_i;
  assign full    = (cnt_q == CAP);
  assign empty   = (cnt_q == '0);
  assign push_ok = push_i & ~full & ~clr;
  assign pop_ok  = pop_i & ~empty & ~clr;

  always_ff @(posedge clk_i) begin
    if (push_ok) mem[wp_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q   <= '0;
      rp_q   <= '0;
      cnt_q  <= '0;
      attn_q <= 1'b0;
    end else if (clr) begin
      wp_q   <= '0;
      rp_q   <= '0;
      cnt_q  <= '0;
      attn_q <= 1'b0;
    end else begin
      if (push_ok) wp_q <= wp_q + 1'b1;
      if (pop_ok)  rp_q <= rp_q + 1'b1;
      cnt_q  <= cnt_q + AW'(push_ok) - AW'(pop_ok);
      attn_q <= push_ok & empty;
    end
  end

  assign done_o  = ~full;
  assign val_o   = ~empty;
  assign size_o  = SIZE_W'(cnt_q);
  assign data_o  = mem[rp_q];
  assign empty_o = empty;
  assign attn_o  = attn_q;
endmodule

// File: rtl/prt_hold.sv
module prt_hold
  import prt_pkg::*;
#(
  parameter int DW = CHAR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              err_rise_i,
  input  logic              push_i,
  input  logic [DW-1:0]     push_data_i,
  input  logic              pop_i,
  output logic              done_o,
  output logic              val_o,
  output logic [SIZE_W-1:0] size_o,
  output logic [DW-1:0]     data_o,
  output logic              empty_o,
  output logic              attn_o
);
  logic          v_q, done_q, attn_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q    <= 1'b0;
      done_q <= 1'b1;
      attn_q <= 1'b0;
      data_q <= '0;
    end else begin
      attn_q <= 1'b0;
      if (flush_i) begin
        v_q    <= 1'b0;
        done_q <= 1'b1;
      end else if (err_rise_i && v_q) begin
        // pending character abandoned, host is told
        v_q    <= 1'b0;
        done_q <= 1'b1;
        attn_q <= 1'b1;
      end else if (push_i) begin
        data_q <= push_data_i;
        v_q    <= 1'b1;
        done_q <= 1'b0;
        attn_q <= 1'b1;
      end else if (pop_i) begin
        v_q    <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  assign done_o  = done_q;
  assign val_o   = v_q;
  assign size_o  = SIZE_W'(v_q);
  assign data_o  = data_q;
  assign empty_o = 1'b0;
  assign attn_o  = attn_q;
endmodule

// File: rtl/prt_port.sv
module prt_port
  import prt_pkg::*;
#(
  parameter int BUF_AW = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_reset_i,
  input  logic        loc_wr_i,
  input  logic        loc_sel_i,
  input  logic [15:0] loc_wdata_i,
  output logic [15:0] loc_rdata_o,
  input  logic        rem_wr_i,
  input  logic        rem_rd_i,
  input  logic        rem_sel_i,
  input  logic [15:0] rem_wdata_i,
  output logic [15:0] rem_rdata_o,
  output logic        rem_err_o,
  output logic        attn_o,
  input  logic        irq_ack_i,
  output logic        irq_o
);
  localparam logic [2:0] TYPE_VAL = 3'(BUF_AW);

  logic loc_st_wr, loc_bf_wr, rem_st_wr, rem_bf_rd;
  logic st_err, st_ie, st_done, err_rise, push;
  logic [RLIM_W-1:0] rlim;
  logic s_val, s_empty;
  logic [SIZE_W-1:0] s_size;
  logic [CHAR_W-1:0] s_data;
  rbuf_t rbuf;

  assign loc_st_wr = loc_wr_i & ~loc_sel_i;
  assign loc_bf_wr = loc_wr_i &  loc_sel_i;
  assign rem_st_wr = rem_wr_i & ~rem_sel_i;
  assign rem_bf_rd = rem_rd_i &  rem_sel_i;
  assign push      = loc_bf_wr & ~st_err & ~err_rise;

  prt_csr u_csr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_reset_i (bus_reset_i),
    .loc_st_wr_i (loc_st_wr),
    .rem_st_wr_i (rem_st_wr),
    .loc_wdata_i (loc_wdata_i),
    .rem_wdata_i (rem_wdata_i),
    .done_i      (st_done),
    .irq_ack_i   (irq_ack_i),
    .err_o       (st_err),
    .err_rise_o  (err_rise),
    .ie_o        (st_ie),
    .rlim_o      (rlim),
    .irq_o       (irq_o)
  );

  if (BUF_AW == 0) begin : g_hold
    prt_hold #(.DW(CHAR_W)) u_store (
      .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(bus_reset_i), .err_rise_i(err_rise),
      .push_i(push), .push_data_i(loc_wdata_i[CHAR_W-1:0]), .pop_i(rem_bf_rd),
      .done_o(st_done), .val_o(s_val), .size_o(s_size), .data_o(s_data),
      .empty_o(s_empty), .attn_o(attn_o)
    );
  end else begin : g_fifo
    prt_fifo #(.AW(BUF_AW), .DW(CHAR_W)) u_store (
      .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(bus_reset_i), .err_rise_i(err_rise),
      .push_i(push), .push_data_i(loc_wdata_i[CHAR_W-1:0]), .pop_i(rem_bf_rd),
      .done_o(st_done), .val_o(s_val), .size_o(s_size), .data_o(s_data),
      .empty_o(s_empty), .attn_o(attn_o)
    );
  end

  assign rbuf = '{val: s_val, size: s_size, pad: 1'b0, data: s_data};
  assign rem_err_o = rem_bf_rd & s_empty;

  always_comb begin
    loc_rdata_o = '0;
    if (!loc_sel_i) begin
      loc_rdata_o[ST_ERR]  = st_err;
      loc_rdata_o[ST_DONE] = st_done;
      loc_rdata_o[ST_IE]   = st_ie;
    end
  end

  always_comb begin
    rem_rdata_o = '0;
    if (rem_sel_i) begin
      if (!s_empty) rem_rdata_o = rbuf;
    end else begin
      rem_rdata_o[ST_ERR]                   = st_err;
      rem_rdata_o[RLIM_LSB +: RLIM_W]       = rlim;
      rem_rdata_o[TYPE_LSB +: 3]            = TYPE_VAL;
      rem_rdata_o[ST_DONE]                  = st_done;
      rem_rdata_o[ST_IE]                    = st_ie;
    end
  end
endmodule

// File: rtl/prt_port_chk.sv
module prt_port_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bus_reset_i,
  input logic loc_wr_i,
  input logic loc_sel_i,
  input logic rem_wr_i,
  input logic rem_rd_i,
  input logic rem_sel_i,
  input logic rem_err_o,
  input logic attn_o,
  input logic irq_o,
  input logic st_err,
  input logic st_done,
  input logic st_ie,
  input logic err_rise
);
  a_r2_busrst_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_i |=> st_done && !st_ie);

  a_r2_err_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_reset_i && !(rem_wr_i && !rem_sel_i)) |=> st_err == $past(st_err));

  a_r7_err_no_attn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_err |=> !attn_o);

  a_r5_full_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!st_done && loc_wr_i && loc_sel_i && !(rem_rd_i && rem_sel_i) && !bus_reset_i && !err_rise)
      |=> !st_done);

  a_r10_irq_cond: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> st_done && st_ie);

  a_r4_err_only_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rem_err_o |-> st_done);
endmodule

bind prt_port prt_port_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_reset_i(bus_reset_i),
  .loc_wr_i(loc_wr_i), .loc_sel_i(loc_sel_i), .rem_wr_i(rem_wr_i),
  .rem_rd_i(rem_rd_i), .rem_sel_i(rem_sel_i), .rem_err_o(rem_err_o),
  .attn_o(attn_o), .irq_o(irq_o), .st_err(st_err), .st_done(st_done),
  .st_ie(st_ie), .err_rise(err_rise)
);

// File: tb/tb_prt_port.sv
`timescale 1ns/1ps
module tb_prt_port;
  localparam logic [2:0] LWB = 3'd0, LWS = 3'd1, RWS = 3'd2, RRB = 3'd3,
                         LRS = 3'd4, BRS = 3'd5, RRS = 3'd6;
  localparam int NV = 38;
  // {op, wdata, exp_err, exp_attn, exp_rdata}
  localparam logic [36:0] VEC [NV] = '{
    {LRS, 16'h0000, 1'b0, 1'b0, 16'h0080},  // R1 reset state
    {RRS, 16'h0000, 1'b0, 1'b0, 16'h0280},  // R9 type=2
    {LWB, 16'h0031, 1'b0, 1'b1, 16'h0000},  // R6 empty -> attn
    {LWB, 16'h0032, 1'b0, 1'b0, 16'h0000},  // R6 no attn
    {LWB, 16'h00F8, 1'b0, 1'b0, 16'h0000},  // R3 truncation, queue full
    {LRS, 16'h0000, 1'b0, 1'b0, 16'h0000},  // R5 done=0 when full
    {LWB, 16'h0033, 1'b0, 1'b0, 16'h0000},  // R5 dropped
    {RRB, 16'h0000, 1'b0, 1'b0, 16'h8331},  // R4 size 3
    {LRS, 16'h0000, 1'b0, 1'b0, 16'h0080},  // R5 done back
    {RRB, 16'h0000, 1'b0, 1'b0, 16'h8232},  // R4
    {RRB, 16'h0000, 1'b0, 1'b0, 16'h8178},  // R3 R4 0x78 kept
    {RRB, 16'h0000, 1'b1, 1'b0, 16'h0000},  // R4 R5 empty read, 0x33 was dropped
    {LWS, 16'h0040, 1'b0, 1'b0, 16'h0000},  // R1 ie local
    {LRS, 16'h0000, 1'b0, 1'b0, 16'h00C0},
    {RWS, 16'h0000, 1'b0, 1'b0, 16'h0000},  // R1 remote cannot clear ie
    {LRS, 16'h0000, 1'b0, 1'b0, 16'h00C0},
    {RWS, 16'h3000, 1'b0, 1'b0, 16'h0000},  // R9 rlim
    {RRS, 16'h0000, 1'b0, 1'b0, 16'h32C0},
    {LRS, 16'h0000, 1'b0, 1'b0, 16'h00C0},  // R9 rlim hidden locally
    {LWS, 16'h8000, 1'b0, 1'b0, 16'h0000},  // R1 local cannot set err
    {LRS, 16'h0000, 1'b0, 1'b0, 16'h0080},
    {LWB, 16'h0041, 1'b0, 1'b1, 16'h0000},
    {LWB, 16'h0042, 1'b0, 1'b0, 16'h0000},
    {RWS, 16'hB000, 1'b0, 1'b0, 16'h0000},  // R7 flush
    {RRS, 16'h0000, 1'b0, 1'b0, 16'hB280},
    {LWB, 16'h0043, 1'b0, 1'b0, 16'h0000},  // R7 discarded, no attn
    {RWS, 16'h3000, 1'b0, 1'b0, 16'h0000},
    {RRB, 16'h0000, 1'b1, 1'b0, 16'h0000},  // R7 queue empty
    {LWB, 16'h0044, 1'b0, 1'b1, 16'h0000},
    {RWS, 16'hB000, 1'b0, 1'b0, 16'h0000},
    {BRS, 16'h0000, 1'b0, 1'b0, 16'h0000},  // R2
    {RRS, 16'h0000, 1'b0, 1'b0, 16'hB280},  // R2 err and rlim kept
    {RWS, 16'h3000, 1'b0, 1'b0, 16'h0000},
    {LWB, 16'h0045, 1'b0, 1'b1, 16'h0000},
    {LWS, 16'h0040, 1'b0, 1'b0, 16'h0000},
    {BRS, 16'h0000, 1'b0, 1'b0, 16'h0000},  // R2
    {LRS, 16'h0000, 1'b0, 1'b0, 16'h0080},  // R2 ie cleared
    {RRB, 16'h0000, 1'b1, 1'b0, 16'h0000}   // R2 queue emptied
  };

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic b_brst = 0, b_lwr = 0, b_lsel = 0, b_rwr = 0, b_rrd = 0, b_rsel = 0, b_ack = 0;
  logic [15:0] b_lwd = 0, b_rwd = 0, b_lrd, b_rrdata;
  logic b_rerr, b_attn, b_irq;
  logic u_brst = 0, u_lwr = 0, u_lsel = 0, u_rwr = 0, u_rrd = 0, u_rsel = 0;
  logic [15:0] u_lwd = 0, u_rwd = 0, u_lrd, u_rrdata;
  logic u_rerr, u_attn, u_irq;

  prt_port #(.BUF_AW(2)) dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_reset_i(b_brst), .loc_wr_i(b_lwr), .loc_sel_i(b_lsel),
    .loc_wdata_i(b_lwd), .loc_rdata_o(b_lrd), .rem_wr_i(b_rwr), .rem_rd_i(b_rrd),
    .rem_sel_i(b_rsel), .rem_wdata_i(b_rwd), .rem_rdata_o(b_rrdata), .rem_err_o(b_rerr),
    .attn_o(b_attn), .irq_ack_i(b_ack), .irq_o(b_irq));

  prt_port #(.BUF_AW(0)) dut0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_reset_i(u_brst), .loc_wr_i(u_lwr), .loc_sel_i(u_lsel),
    .loc_wdata_i(u_lwd), .loc_rdata_o(u_lrd), .rem_wr_i(u_rwr), .rem_rd_i(u_rrd),
    .rem_sel_i(u_rsel), .rem_wdata_i(u_rwd), .rem_rdata_o(u_rrdata), .rem_err_o(u_rerr),
    .attn_o(u_attn), .irq_ack_i(1'b0), .irq_o(u_irq));

  int n_chk = 0, n_fail = 0;
  bit fin = 0;
  logic [15:0] g_rd;
  logic g_err, g_attn;

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic op(input bit u, input logic [2:0] k, input logic [15:0] d);
    logic lwr, lsel, rwr, rrd, rsel, brst;
    lwr = (k == LWB) || (k == LWS);
    lsel = (k == LWB);
    rwr = (k == RWS);
    rrd = (k == RRB);
    rsel = (k == RRB);
    brst = (k == BRS);
    @(negedge clk);
    if (u) begin
      u_lwr = lwr; u_lsel = lsel; u_lwd = d; u_rwr = rwr; u_rrd = rrd;
      u_rsel = rsel; u_rwd = d; u_brst = brst;
    end else begin
      b_lwr = lwr; b_lsel = lsel; b_lwd = d; b_rwr = rwr; b_rrd = rrd;
      b_rsel = rsel; b_rwd = d; b_brst = brst;
    end
    #1;
    if (k == LRS) g_rd = u ? u_lrd : b_lrd;
    else          g_rd = u ? u_rrdata : b_rrdata;
    g_err = u ? u_rerr : b_rerr;
    @(posedge clk);
    #1;
    g_attn = u ? u_attn : b_attn;
    u_lwr = 0; u_rwr = 0; u_rrd = 0; u_brst = 0; u_lsel = 0; u_rsel = 0;
    b_lwr = 0; b_rwr = 0; b_rrd = 0; b_brst = 0; b_lsel = 0; b_rsel = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [2:0] k;
      k = VEC[i][36:34];
      op(1'b0, k, VEC[i][33:18]);
      if (k == LRS) chk($sformatf("R1 vec %0d local status", i), g_rd, VEC[i][15:0]);
      if (k == RRS) chk($sformatf("R9 vec %0d remote status", i), g_rd, VEC[i][15:0]);
      if (k == RRB) begin
        chk($sformatf("R4 vec %0d remote data", i), g_rd, VEC[i][15:0]);
        chk($sformatf("R4 vec %0d empty error", i), 16'(g_err), 16'(VEC[i][17]));
      end
      chk($sformatf("R6 vec %0d attention", i), 16'(g_attn), 16'(VEC[i][16]));
    end

    // R10 interrupt edge, ack and re-arm
    op(1'b0, LWS, 16'h0040);
    @(posedge clk); #1;
    chk("R10 irq raised", 16'(b_irq), 16'd1);
    @(negedge clk); b_ack = 1;
    @(posedge clk); #1; b_ack = 0;
    chk("R10 irq cleared by ack", 16'(b_irq), 16'd0);
    repeat (3) @(posedge clk); #1;
    chk("R10 no re-raise while held", 16'(b_irq), 16'd0);
    op(1'b0, LWB, 16'h0001);
    op(1'b0, LWB, 16'h0002);
    op(1'b0, LWB, 16'h0003);
    chk("R10 irq low when full", 16'(b_irq), 16'd0);
    op(1'b0, RRB, 16'h0);
    chk("R4 size of full queue", g_rd, 16'h8301);
    @(posedge clk); #1;
    chk("R10 irq on done rise", 16'(b_irq), 16'd1);
    op(1'b0, LWS, 16'h0000);
    @(posedge clk); #1;
    chk("R10 irq drops with ie", 16'(b_irq), 16'd0);

    // R8 unbuffered variant
    op(1'b1, RRS, 16'h0);
    chk("R9 unbuffered type 0", g_rd, 16'h0080);
    op(1'b1, LWB, 16'h0107);
    chk("R8 write attention", 16'(g_attn), 16'd1);
    op(1'b1, LRS, 16'h0);
    chk("R8 done cleared", g_rd, 16'h0000);
    op(1'b1, RRB, 16'h0);
    chk("R3 R8 read pending char", g_rd, 16'h8107);
    chk("R8 no error", 16'(g_err), 16'd0);
    op(1'b1, LRS, 16'h0);
    chk("R8 done after read", g_rd, 16'h0080);
    op(1'b1, LWB, 16'h0032);
    op(1'b1, RWS, 16'h8000);
    chk("R8 err on pending attention", 16'(g_attn), 16'd1);
    op(1'b1, LRS, 16'h0);
    chk("R8 done and err set", g_rd, 16'h8080);
    op(1'b1, LWB, 16'h0055);
    chk("R7 unbuffered discard no attn", 16'(g_attn), 16'd0);
    op(1'b1, RWS, 16'h0000);
    op(1'b1, RRB, 16'h0);
    chk("R8 invalid char", g_rd, 16'h0032);
    op(1'b1, RRB, 16'h0);
    chk("R8 empty read no error", 16'(g_err), 16'd0);
    op(1'b1, LWB, 16'h0020);
    op(1'b1, BRS, 16'h0);
    op(1'b1, LRS, 16'h0);
    chk("R2 unbuffered reset done", g_rd, 16'h0080);

    fin = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule